// File: doc/BRIEF.md
# Hardware LRU Chunk List

This block keeps the usage order of a fixed set of cache chunks. The order lives in a doubly linked list: every chunk has a forward pointer, a backward pointer and a membership bit, and two registers mark the most-recently-used (MRU) end and the least-recently-used (LRU) end. The data path reports every chunk it touches on a fire-and-forget notification port. These reports enter a small queue and are applied to the list later, so the requester never waits on the list.

A separate command port is used by the cache manager. INSERT links a newly allocated chunk in at the MRU end. DEQUEUE unlinks the chunk at the LRU end and returns its index, which is the eviction victim. Each list operation finishes in one cycle and writes at most four pointers. Commands are always accepted and take priority over queued notifications.

Top module: `lru_chunk_list`

## Requirements
- R1: After reset the list is empty and `rsp_valid` is low. It stays low until a DEQUEUE is issued.
- R2: INSERT (`cmd_op` = 0) of a chunk not in the list links it in at the MRU end. Chunks that are inserted and never accessed leave the list in the order they were inserted, oldest first.
- R3: DEQUEUE (`cmd_op` = 1) is answered in the cycle after the one in which it is presented. The answer has `rsp_valid` high and `rsp_idx` set to the LRU chunk, and that chunk is removed from the list.
- R4: DEQUEUE on an empty list answers with `rsp_empty` high and `rsp_idx` = 0, and the list is left unchanged.
- R5: An applied notification moves the named chunk to the MRU end. A notification for the chunk already at the MRU end leaves the order unchanged.
- R6: A notification for a chunk that is not in the list when the notification is applied has no effect. An INSERT of a chunk that is already in the list has no effect.
- R7: Notifications wait in a queue of `NOTE_DEPTH` entries. One entry is applied per cycle, and only in a cycle with no command. A notification is stored only if the queue held fewer than `NOTE_DEPTH` entries at the start of its cycle; otherwise it is dropped.
- R8: Queued notifications are applied in the order they arrived.
- R9: The list never holds more than `N_CHUNKS` chunks. After all chunks have been inserted, DEQUEUE returns each chunk exactly once before the list reports empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access notification strobe |
| acc_idx | input | $clog2(N_CHUNKS) | Chunk touched by the data path |
| cmd_valid | input | 1 | Command strobe, always accepted |
| cmd_op | input | 1 | 0 = INSERT, 1 = DEQUEUE |
| cmd_idx | input | $clog2(N_CHUNKS) | Chunk to insert (ignored for DEQUEUE) |
| rsp_valid | output | 1 | DEQUEUE answer present |
| rsp_empty | output | 1 | DEQUEUE found the list empty |
| rsp_idx | output | $clog2(N_CHUNKS) | Victim chunk returned by DEQUEUE |

## Verification
The hardest situation to reach is a full notification queue. The queue drains one entry per idle cycle, so it fills only while commands keep the list busy. The stimulus holds the command port busy with INSERTs of chunks already in the list, which change nothing, while notifications arrive every cycle. This overflows the queue, and the list contents that result are then read out by a run of DEQUEUEs. A second hard case is a stale notification: one that is still queued when its chunk is dequeued. Random traffic that mixes frequent DEQUEUEs with a steady flow of notifications produces it.

// File: rtl/lru_pkg.sv
package lru_pkg;
    typedef enum logic {
        OP_INSERT  = 1'b0,
        OP_DEQUEUE = 1'b1
    } lru_op_e;
endpackage

// File: rtl/lru_note_fifo.sv
module lru_note_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [LW-1:0]           lvl;
    } fifo_t;

    fifo_t s_q, s_d;
    logic  do_pop, do_push;

    always_comb begin
        s_d     = s_q;
        // space and data are judged on the state at the start of the cycle
        do_pop  = pop && (s_q.lvl != '0);
        do_push = push_valid && (s_q.lvl != LW'(DEPTH));
        if (do_pop) begin
            s_d.rd = (s_q.rd == PW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        if (do_push) begin
            s_d.mem[s_q.wr] = push_data;
            s_d.wr = (s_q.wr == PW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        s_d.lvl = s_q.lvl + LW'(do_push) - LW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = (s_q.lvl != '0);
    assign out_data  = s_q.mem[s_q.rd];
    assign level     = s_q.lvl;
endmodule

// File: rtl/lru_list_core.sv
module lru_list_core
    import lru_pkg::*;
#(
    parameter int N    = 16,
    localparam int IW  = $clog2(N),
    localparam int CW  = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  lru_op_e       cmd_op,
    input  logic [IW-1:0] cmd_idx,
    input  logic          note_valid,
    input  logic [IW-1:0] note_idx,
    output logic          note_pop,
    output logic          rsp_valid,
    output logic          rsp_empty,
    output logic [IW-1:0] rsp_idx,
    output logic [CW-1:0] occ
);
    typedef struct packed {
        logic [N-1:0][IW-1:0] nxt;   // toward LRU end
        logic [N-1:0][IW-1:0] prv;   // toward MRU end
        logic [N-1:0]         mem;   // chunk is linked
        logic [IW-1:0]        head;  // MRU
        logic [IW-1:0]        tail;  // LRU
        logic [CW-1:0]        cnt;
        logic                 rv;
        logic                 re;
        logic [IW-1:0]        ri;
    } list_t;

    list_t         s_q, s_d;
    logic [IW-1:0] p_sel, n_sel;

    assign note_pop = note_valid && !cmd_valid;

    always_comb begin
        s_d   = s_q;
        s_d.rv = 1'b0;
        s_d.re = 1'b0;
        s_d.ri = '0;
        p_sel = s_q.prv[note_idx];
        n_sel = s_q.nxt[note_idx];
        if (cmd_valid) begin
            if (cmd_op == OP_DEQUEUE) begin
                s_d.rv = 1'b1;
                if (s_q.cnt == '0) begin
                    s_d.re = 1'b1;
                end else begin
                    s_d.ri            = s_q.tail;
                    s_d.mem[s_q.tail] = 1'b0;
                    s_d.cnt           = s_q.cnt - 1'b1;
                    if (s_q.cnt != CW'(1)) s_d.tail = s_q.prv[s_q.tail];
                end
            end else if (!s_q.mem[cmd_idx]) begin
                s_d.mem[cmd_idx] = 1'b1;
                s_d.cnt          = s_q.cnt + 1'b1;
                s_d.nxt[cmd_idx] = s_q.head;
                s_d.prv[cmd_idx] = '0;
                s_d.head         = cmd_idx;
                if (s_q.cnt == '0) s_d.tail = cmd_idx;
                else               s_d.prv[s_q.head] = cmd_idx;
            end
        end else if (note_valid && s_q.mem[note_idx] && note_idx != s_q.head) begin
            // unlink from its position, then link at the MRU end
            s_d.nxt[p_sel] = n_sel;
            if (note_idx == s_q.tail) s_d.tail = p_sel;
            else                      s_d.prv[n_sel] = p_sel;
            s_d.nxt[note_idx] = s_q.head;
            s_d.prv[s_q.head] = note_idx;
            s_d.head          = note_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rv;
    assign rsp_empty = s_q.re;
    assign rsp_idx   = s_q.ri;
    assign occ       = s_q.cnt;
endmodule

// File: rtl/lru_chunk_list.sv
module lru_chunk_list
    import lru_pkg::*;
#(
    parameter int N_CHUNKS   = 16,
    parameter int NOTE_DEPTH = 4,
    localparam int IW = $clog2(N_CHUNKS),
    localparam int CW = $clog2(N_CHUNKS + 1),
    localparam int LW = $clog2(NOTE_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [IW-1:0] acc_idx,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [IW-1:0] cmd_idx,
    output logic          rsp_valid,
    output logic          rsp_empty,
    output logic [IW-1:0] rsp_idx
);
    logic          note_valid, note_pop;
    logic [IW-1:0] note_idx;
    logic [LW-1:0] note_lvl;
    logic [CW-1:0] list_occ;

    lru_note_fifo #(.DEPTH(NOTE_DEPTH), .W(IW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (acc_valid),
        .push_data  (acc_idx),
        .pop        (note_pop),
        .out_valid  (note_valid),
        .out_data   (note_idx),
        .level      (note_lvl)
    );

    lru_list_core #(.N(N_CHUNKS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (lru_op_e'(cmd_op)),
        .cmd_idx    (cmd_idx),
        .note_valid (note_valid),
        .note_idx   (note_idx),
        .note_pop   (note_pop),
        .rsp_valid  (rsp_valid),
        .rsp_empty  (rsp_empty),
        .rsp_idx    (rsp_idx),
        .occ        (list_occ)
    );
endmodule

// File: rtl/lru_chunk_list_chk.sv
module lru_chunk_list_chk #(
    parameter int N_CHUNKS   = 16,
    parameter int NOTE_DEPTH = 4,
    localparam int IW = $clog2(N_CHUNKS),
    localparam int CW = $clog2(N_CHUNKS + 1),
    localparam int LW = $clog2(NOTE_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_op,
    input logic          rsp_valid,
    input logic          rsp_empty,
    input logic [IW-1:0] rsp_idx,
    input logic [CW-1:0] list_occ,
    input logic [LW-1:0] note_lvl
);
    p_rsp_needs_deq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_op));

    p_deq_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op) |=> rsp_valid);

    p_deq_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op && list_occ != '0) |=> (list_occ == $past(list_occ) - CW'(1)));

    p_empty_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op && list_occ == '0) |=> (rsp_empty && rsp_idx == '0 && list_occ == '0));

    p_full_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (note_lvl == LW'(NOTE_DEPTH) && cmd_valid) |=> (note_lvl == LW'(NOTE_DEPTH)));

    p_queue_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        note_lvl <= LW'(NOTE_DEPTH));

    p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        list_occ <= CW'(N_CHUNKS));
endmodule

bind lru_chunk_list lru_chunk_list_chk #(
    .N_CHUNKS   (N_CHUNKS),
    .NOTE_DEPTH (NOTE_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_empty (rsp_empty),
    .rsp_idx   (rsp_idx),
    .list_occ  (list_occ),
    .note_lvl  (note_lvl)
);

// File: tb/sim_lru_chunk_list.sv
`timescale 1ns/1ps
module sim_lru_chunk_list;
    localparam int N  = 16;
    localparam int D  = 4;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [IW-1:0] cmd_idx = '0;
    logic          rsp_valid, rsp_empty;
    logic [IW-1:0] rsp_idx;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // reference state: lst[0] is the MRU end
    int   lst[$];
    int   fq[$];
    logic exp_v = 1'b0, exp_e = 1'b0;
    int   exp_i = 0;

    always #2.5 clk = ~clk;

    lru_chunk_list #(.N_CHUNKS(N), .NOTE_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .rsp_valid(rsp_valid), .rsp_empty(rsp_empty), .rsp_idx(rsp_idx)
    );

    function automatic int find(int x);
        foreach (lst[k]) if (lst[k] == x) return k;
        return -1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            lst.delete(); fq.delete();
            exp_v <= 1'b0; exp_e <= 1'b0; exp_i <= 0;
        end else begin
            automatic int sz = fq.size();
            automatic int ev = 0, ee = 0, ei = 0;
            if (cmd_valid) begin
                if (cmd_op) begin
                    ev = 1;
                    if (lst.size() == 0) ee = 1;
                    else ei = lst.pop_back();
                end else if (find(int'(cmd_idx)) < 0) begin
                    lst.push_front(int'(cmd_idx));
                end
            end else if (sz > 0) begin
                automatic int y = fq.pop_front();
                automatic int k = find(y);
                if (k >= 0) begin
                    lst.delete(k);
                    lst.push_front(y);
                end
            end
            if (acc_valid && sz < D) fq.push_back(int'(acc_idx));
            exp_v <= 1'(ev); exp_e <= 1'(ee); exp_i <= ei;
        end
    end

    always @(negedge clk) begin
        if (rst_n && (exp_v || rsp_valid)) begin
            chk({cur_req, " rsp_valid"}, int'(rsp_valid), int'(exp_v));
            if (exp_v) begin
                chk({cur_req, " rsp_empty"}, int'(rsp_empty), int'(exp_e));
                chk({cur_req, " rsp_idx"}, int'(rsp_idx), exp_i);
            end
        end
    end

    task automatic cyc(input logic cv, input logic op, input int ci,
                       input logic av, input int ai);
        cmd_valid = cv; cmd_op = op; cmd_idx = IW'(ci);
        acc_valid = av; acc_idx = IW'(ai);
        @(negedge clk);
    endtask

    task automatic ins(input int x);   cyc(1'b1, 1'b0, x, 1'b0, 0); endtask
    task automatic deq();              cyc(1'b1, 1'b1, 0, 1'b0, 0); endtask
    task automatic note(input int x);  cyc(1'b0, 1'b0, 0, 1'b1, x); endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 0, 1'b0, 0);
    endtask
    task automatic drain();
        for (int k = 0; k <= N; k++) deq();
        idle(1);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset, empty list
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        cur_req = "R1 R4 empty dequeue";
        deq(); idle(1);
        chk("R4 empty flag", int'(rsp_empty), 0); // pulse gone one cycle later

        // R2 R3: insertion order, LRU comes out first
        cur_req = "R2 R3 insert order";
        for (int k = 0; k < 6; k++) ins(k);
        deq(); deq(); deq();
        drain();

        // R5: access middle, tail, head
        cur_req = "R5 move to front";
        for (int k = 0; k < 5; k++) ins(k + 3);
        note(5); note(3); note(3); idle(4);
        drain();

        // R6: stale notification and duplicate insert
        cur_req = "R6 ignored inputs";
        ins(2); ins(9); ins(4);
        note(11); idle(2);
        ins(2); idle(1);
        drain();

        // R7: hold commands busy so the queue fills and overflows
        cur_req = "R7 queue overflow";
        for (int k = 0; k < 8; k++) ins(k);
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 0, 1'b1, k);
        idle(D + 2);
        drain();

        // R8: arrival order of back-to-back notifications
        cur_req = "R8 arrival order";
        for (int k = 0; k < 6; k++) ins(k);
        note(1); note(4); note(0); note(2);
        idle(D + 2);
        drain();

        // R9: full list, every chunk exactly once, then empty
        cur_req = "R9 full list";
        for (int k = 0; k < N; k++) ins(N - 1 - k);
        ins(3);
        drain();

        // mixed random traffic
        cur_req = "R3 R5 R6 R7 random";
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4000; k++) begin
            automatic int r = $urandom_range(0, 99);
            cyc(r < 35, $urandom_range(0, 99) < 40, $urandom_range(0, N - 1),
                $urandom_range(0, 1) == 1, $urandom_range(0, N - 1));
        end
        idle(D + 2);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule